// File: doc/BRIEF.md
# Logic Analyzer Host Command Decoder

This block sits behind the receive side of a host serial link in a logic analyzer. It takes the incoming byte stream and frames it into commands. An opcode byte with its top bit clear is a short command and takes effect on its own. An opcode byte with its top bit set opens a long command, which carries four more bytes of argument. Short commands become single-cycle control pulses for reset, run and metadata request. The identify command starts a fixed four-byte signature back to the host through a valid/ready transmit handshake.

Each completed long command produces one write strobe with its opcode and 32-bit argument. The block also holds four configuration registers decoded from those writes: the sample-rate divider, the capture length, the post-trigger length and the capture flags. It also holds an armed bit that run sets. A reset byte at the opcode position clears all of this state and cuts off a reply that is still being sent. The host can restore framing from any unknown position by sending the reset byte five times in a row. The zeros first fill whatever argument slots are still open, and the remaining ones land on the opcode position.

Top module: `lac_cmd_decoder`

## Requirements
- R1: After the synchronous reset `rst`, all configuration registers read zero, `armed` is 0, and `tx_valid`, `wr_strobe`, `soft_rst`, `run_pulse` and `meta_pulse` are all 0.
- R2: An opcode with bit 7 set is followed by four argument bytes, least significant first. In the cycle after the fourth argument byte is accepted, `wr_strobe` is high for exactly one cycle, with that opcode on `wr_opcode` and the assembled argument on `wr_arg`.
- R3: An opcode with bit 7 clear arriving at the opcode position takes effect one cycle after it is accepted. 0x01 gives one `run_pulse` and sets `armed`. 0x04 gives one `meta_pulse`. Any other short opcode except 0x00 and 0x02 produces no pulse and changes no state.
- R4: A 0x00 byte at the opcode position gives one `soft_rst` pulse. On the following edge it clears every configuration register and `armed`, and it stops any signature transmission in progress.
- R5: Five consecutive 0x00 bytes bring the framer back to the opcode position from any point inside a long command. Any argument slots still open are completed with zero bytes and written out.
- R6: Opcode 0x02 starts a reply of the four bytes 0x31, 0x53, 0x4C, 0x4F in that order on `tx_byte`. Each byte is held with `tx_valid` high until a cycle in which `tx_ready` is high.
- R7: An identify opcode received while a reply is still being sent is ignored, and no extra bytes are sent.
- R8: Long opcode 0x80 loads `divider` with argument bits 23:0. The top argument byte is discarded.
- R9: Long opcode 0x82 loads `flags` with argument bits 15:0. The upper half is discarded.
- R10: Long opcode 0x81 loads `cap_len` and long opcode 0x83 loads `post_len`, each with the full 32-bit argument. Any other long opcode only strobes and leaves every register unchanged.
- R11: A byte on `rx_byte` while `rx_valid` is low is not accepted and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | Signature byte offered to the transmitter |
| tx_ready | input | 1 | Transmitter takes the offered byte this cycle |
| tx_byte | output | 8 | Signature byte |
| wr_strobe | output | 1 | One-cycle write strobe for a completed long command |
| wr_opcode | output | 8 | Opcode of the long command |
| wr_arg | output | 32 | Little-endian assembled argument |
| soft_rst | output | 1 | Pulse for a reset command |
| run_pulse | output | 1 | Pulse for a run command |
| meta_pulse | output | 1 | Pulse for a metadata request |
| armed | output | 1 | Set by run, cleared by reset command |
| divider | output | 24 | Sample-rate divider register |
| cap_len | output | 32 | Capture length register |
| post_len | output | 32 | Post-trigger length register |
| flags | output | 16 | Capture flags register |

## Verification
Pulses and the write strobe are registered, so they appear in the cycle after the edge that accepts the byte. The bench presents each byte for one clock between falling edges and counts pulses and strobes at the next falling edge, when they are high. Register contents change one edge after the strobe or reset pulse, so register checks wait two full cycles after the last byte. Signature bytes are due from the cycle after the identify pulse. Each byte is compared only when `tx_valid` and `tx_ready` are both high at a falling edge, and `tx_ready` changes only just after rising edges, so stalls of any length keep the expected order intact.

// File: rtl/lac_pkg.sv
package lac_pkg;
    typedef logic [7:0] byte_t;

    localparam byte_t OP_RESET = 8'h00;
    localparam byte_t OP_RUN   = 8'h01;
    localparam byte_t OP_IDENT = 8'h02;
    localparam byte_t OP_META  = 8'h04;
    localparam byte_t OP_DIV   = 8'h80;
    localparam byte_t OP_LEN   = 8'h81;
    localparam byte_t OP_FLAGS = 8'h82;
    localparam byte_t OP_POST  = 8'h83;

    localparam int ID_LEN = 4;
    localparam int ID_IDX_W = $clog2(ID_LEN);

    function automatic byte_t id_sig(input logic [ID_IDX_W-1:0] idx);
        case (idx)
            2'd0:    return 8'h31;
            2'd1:    return 8'h53;
            2'd2:    return 8'h4C;
            default: return 8'h4F;
        endcase
    endfunction
endpackage

// File: rtl/lac_framer.sv
module lac_framer
    import lac_pkg::*;
#(
    parameter int ARG_BYTES = 4,
    localparam int ARG_W = 8 * ARG_BYTES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  byte_t            in_byte,
    output logic             short_valid,
    output byte_t            short_op,
    output logic             long_valid,
    output byte_t            long_op,
    output logic [ARG_W-1:0] long_arg
);
    localparam int CNT_W = $clog2(ARG_BYTES + 1);

    logic [CNT_W-1:0] slot;
    byte_t            op_hold;
    logic [ARG_W-1:0] acc;
    logic [ARG_W-1:0] acc_next;

    assign acc_next = {in_byte, acc[ARG_W-1:8]};

    always_ff @(posedge clk) begin
        if (rst) begin
            slot        <= '0;
            op_hold     <= '0;
            acc         <= '0;
            short_valid <= 1'b0;
            short_op    <= '0;
            long_valid  <= 1'b0;
            long_op     <= '0;
            long_arg    <= '0;
        end else begin
            short_valid <= 1'b0;
            long_valid  <= 1'b0;
            if (in_valid) begin
                if (slot == '0) begin
                    if (in_byte[7]) begin
                        op_hold <= in_byte;
                        slot    <= CNT_W'(1);
                    end else begin
                        short_valid <= 1'b1;
                        short_op    <= in_byte;
                    end
                end else begin
                    acc <= acc_next;
                    if (slot == CNT_W'(ARG_BYTES)) begin
                        slot       <= '0;
                        long_valid <= 1'b1;
                        long_op    <= op_hold;
                        long_arg   <= acc_next;
                    end else begin
                        slot <= slot + CNT_W'(1);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/lac_cfg_bank.sv
module lac_cfg_bank
    import lac_pkg::*;
#(
    parameter int ARG_W  = 32,
    parameter int DIV_W  = 24,
    parameter int FLAG_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              run,
    input  logic              wr_en,
    input  byte_t             wr_op,
    input  logic [ARG_W-1:0]  wr_val,
    output logic              armed,
    output logic [DIV_W-1:0]  divider,
    output logic [ARG_W-1:0]  cap_len,
    output logic [ARG_W-1:0]  post_len,
    output logic [FLAG_W-1:0] flags
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            armed    <= 1'b0;
            divider  <= '0;
            cap_len  <= '0;
            post_len <= '0;
            flags    <= '0;
        end else begin
            if (run) armed <= 1'b1;
            if (wr_en) begin
                case (wr_op)
                    OP_DIV:   divider  <= wr_val[DIV_W-1:0];
                    OP_LEN:   cap_len  <= wr_val;
                    OP_FLAGS: flags    <= wr_val[FLAG_W-1:0];
                    OP_POST:  post_len <= wr_val;
                    default:  ;
                endcase
            end
        end
    end
endmodule

// File: rtl/lac_id_tx.sv
module lac_id_tx
    import lac_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  abort,
    input  logic  tx_ready,
    output logic  tx_valid,
    output byte_t tx_byte
);
    logic                busy;
    logic [ID_IDX_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                idx  <= '0;
            end
        end else if (tx_ready) begin
            if (idx == ID_IDX_W'(ID_LEN - 1)) begin
                busy <= 1'b0;
                idx  <= '0;
            end else begin
                idx <= idx + ID_IDX_W'(1);
            end
        end
    end

    assign tx_valid = busy;
    assign tx_byte  = id_sig(idx);
endmodule

// File: rtl/lac_cmd_decoder.sv
module lac_cmd_decoder
    import lac_pkg::*;
#(
    parameter int ARG_BYTES = 4,
    parameter int DIV_W     = 24,
    parameter int FLAG_W    = 16,
    localparam int ARG_W    = 8 * ARG_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_byte,
    output logic              wr_strobe,
    output logic [7:0]        wr_opcode,
    output logic [ARG_W-1:0]  wr_arg,
    output logic              soft_rst,
    output logic              run_pulse,
    output logic              meta_pulse,
    output logic              armed,
    output logic [DIV_W-1:0]  divider,
    output logic [ARG_W-1:0]  cap_len,
    output logic [ARG_W-1:0]  post_len,
    output logic [FLAG_W-1:0] flags
);
    logic  short_valid;
    byte_t short_op;
    logic  id_start;

    lac_framer #(.ARG_BYTES(ARG_BYTES)) u_framer (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (rx_valid),
        .in_byte    (rx_byte),
        .short_valid(short_valid),
        .short_op   (short_op),
        .long_valid (wr_strobe),
        .long_op    (wr_opcode),
        .long_arg   (wr_arg)
    );

    assign soft_rst   = short_valid && (short_op == OP_RESET);
    assign run_pulse  = short_valid && (short_op == OP_RUN);
    assign meta_pulse = short_valid && (short_op == OP_META);
    assign id_start   = short_valid && (short_op == OP_IDENT);

    lac_cfg_bank #(.ARG_W(ARG_W), .DIV_W(DIV_W), .FLAG_W(FLAG_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .clear   (soft_rst),
        .run     (run_pulse),
        .wr_en   (wr_strobe),
        .wr_op   (wr_opcode),
        .wr_val  (wr_arg),
        .armed   (armed),
        .divider (divider),
        .cap_len (cap_len),
        .post_len(post_len),
        .flags   (flags)
    );

    lac_id_tx u_idtx (
        .clk     (clk),
        .rst     (rst),
        .start   (id_start),
        .abort   (soft_rst),
        .tx_ready(tx_ready),
        .tx_valid(tx_valid),
        .tx_byte (tx_byte)
    );
endmodule

// File: rtl/lac_cmd_decoder_chk.sv
module lac_cmd_decoder_chk #(
    parameter int DIV_W  = 24,
    parameter int FLAG_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_strobe,
    input logic              soft_rst,
    input logic              run_pulse,
    input logic              meta_pulse,
    input logic              armed,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [7:0]        tx_byte,
    input logic [DIV_W-1:0]  divider,
    input logic [FLAG_W-1:0] flags
);
    // R2: a strobe lasts one cycle (frames need at least five bytes)
    p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |=> !wr_strobe);

    // R3: one byte yields at most one kind of action
    p_pulse_excl_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({soft_rst, run_pulse, meta_pulse, wr_strobe}));

    p_run_arms_r3: assert property (@(posedge clk) disable iff (rst)
        run_pulse |=> armed);

    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (!armed && divider == '0 && flags == '0 && !tx_valid));

    p_tx_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !soft_rst) |=> (tx_valid && $stable(tx_byte)));

    p_tx_code_r6: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (tx_byte == 8'h31 || tx_byte == 8'h53 ||
                      tx_byte == 8'h4C || tx_byte == 8'h4F));
endmodule

bind lac_cmd_decoder lac_cmd_decoder_chk #(.DIV_W(DIV_W), .FLAG_W(FLAG_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_strobe (wr_strobe),
    .soft_rst  (soft_rst),
    .run_pulse (run_pulse),
    .meta_pulse(meta_pulse),
    .armed     (armed),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_byte   (tx_byte),
    .divider   (divider),
    .flags     (flags)
);

// File: tb/lac_cmd_decoder_test.sv
module lac_cmd_decoder_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        tx_ready = 1'b0;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        wr_strobe;
    logic [7:0]  wr_opcode;
    logic [31:0] wr_arg;
    logic        soft_rst, run_pulse, meta_pulse, armed;
    logic [23:0] divider;
    logic [31:0] cap_len, post_len;
    logic [15:0] flags;

    int n_tests = 0;
    int n_fail  = 0;
    int n_rst = 0, n_run = 0, n_meta = 0, n_tx = 0;
    int ready_mode = 0;
    int cyc = 0;
    logic [39:0] strobe_q[$];
    logic [7:0]  tx_q[$];

    always #5 clk = ~clk;

    lac_cmd_decoder uut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
        .wr_strobe(wr_strobe), .wr_opcode(wr_opcode), .wr_arg(wr_arg),
        .soft_rst(soft_rst), .run_pulse(run_pulse), .meta_pulse(meta_pulse),
        .armed(armed), .divider(divider), .cap_len(cap_len),
        .post_len(post_len), .flags(flags)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1;
        case (ready_mode)
            0:       tx_ready = 1'b0;
            1:       tx_ready = 1'b1;
            default: tx_ready = (cyc % 3 == 0);
        endcase
    end

    // monitor: pulses, strobes and signature bytes
    always @(negedge clk) begin
        if (!rst) begin
            if (soft_rst)   n_rst++;
            if (run_pulse)  n_run++;
            if (meta_pulse) n_meta++;
            if (wr_strobe) begin
                if (strobe_q.size() == 0)
                    check(0, "R2 unexpected strobe", {wr_opcode, wr_arg}, 0);
                else begin
                    logic [39:0] e;
                    e = strobe_q.pop_front();
                    check({wr_opcode, wr_arg} == e, "R2 strobe content", {wr_opcode, wr_arg}, e);
                end
            end
            if (tx_valid && tx_ready) begin
                n_tx++;
                if (tx_q.size() == 0)
                    check(0, "R7 extra signature byte", tx_byte, 0);
                else begin
                    logic [7:0] e;
                    e = tx_q.pop_front();
                    check(tx_byte == e, "R6 signature byte", tx_byte, e);
                end
            end
        end
    end

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_byte  = 8'h00;
    endtask

    task automatic send_long(input logic [7:0] op, input logic [31:0] arg);
        strobe_q.push_back({op, arg});
        send(op);
        for (int i = 0; i < 4; i++) send(arg[8*i +: 8]);
    endtask

    task automatic expect_id();
        tx_q.push_back(8'h31); tx_q.push_back(8'h53);
        tx_q.push_back(8'h4C); tx_q.push_back(8'h4F);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int r0, m0, t0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(divider == 0 && cap_len == 0 && post_len == 0 && flags == 0, "R1 regs zero",
              {divider, flags}, 0);
        check(!armed && !tx_valid && !wr_strobe && !soft_rst && !run_pulse && !meta_pulse,
              "R1 outputs idle", {armed, tx_valid, wr_strobe}, 0);

        // R8 and R2
        send_long(8'h80, 32'hFFAB1234);
        idle(2);
        check(divider == 24'hAB1234, "R8 divider low 24 bits", divider, 24'hAB1234);

        // R10
        send_long(8'h81, 32'h89ABCDEF);
        send_long(8'h83, 32'h00010203);
        idle(2);
        check(cap_len == 32'h89ABCDEF, "R10 cap_len", cap_len, 32'h89ABCDEF);
        check(post_len == 32'h00010203, "R10 post_len", post_len, 32'h00010203);

        // R9
        send_long(8'h82, 32'hDEAD5A5A);
        idle(2);
        check(flags == 16'h5A5A, "R9 flags low half", flags, 16'h5A5A);

        // R10 unknown long opcode only strobes
        send_long(8'h90, 32'h11223344);
        idle(2);
        check(divider == 24'hAB1234 && cap_len == 32'h89ABCDEF && post_len == 32'h00010203
              && flags == 16'h5A5A, "R10 unknown long leaves regs", flags, 16'h5A5A);
        check(strobe_q.size() == 0, "R2 all strobes seen", strobe_q.size(), 0);

        // R11
        r0 = n_run;
        @(negedge clk);
        rx_byte = 8'h01;
        idle(4);
        rx_byte = 8'h00;
        idle(2);
        check(n_run == r0 && !armed, "R11 byte without valid ignored", n_run - r0, 0);

        // R3 unknown short opcodes
        r0 = n_rst + n_run + n_meta;
        send(8'h05); send(8'h7F);
        idle(2);
        check(n_rst + n_run + n_meta == r0 && !tx_valid, "R3 unknown short no pulse",
              n_rst + n_run + n_meta - r0, 0);
        check(divider == 24'hAB1234 && flags == 16'h5A5A && !armed, "R3 unknown short no state",
              divider, 24'hAB1234);

        // R3 run and meta
        r0 = n_run; m0 = n_meta;
        send(8'h01);
        idle(1);
        check(n_run == r0 + 1 && armed, "R3 run pulse and armed", n_run - r0, 1);
        send(8'h04);
        idle(1);
        check(n_meta == m0 + 1, "R3 meta pulse", n_meta - m0, 1);

        // R6 identify with ready high
        ready_mode = 1;
        t0 = n_tx;
        expect_id();
        send(8'h02);
        idle(10);
        check(n_tx == t0 + 4 && tx_q.size() == 0, "R6 four bytes sent", n_tx - t0, 4);

        // R6 with stalls
        ready_mode = 2;
        t0 = n_tx;
        expect_id();
        send(8'h02);
        idle(30);
        check(n_tx == t0 + 4 && !tx_valid, "R6 stalled reply complete", n_tx - t0, 4);

        // R7 identify while busy
        ready_mode = 0;
        t0 = n_tx;
        expect_id();
        send(8'h02);
        send(8'h02);
        idle(3);
        ready_mode = 1;
        idle(12);
        check(n_tx == t0 + 4 && tx_q.size() == 0, "R7 second identify ignored", n_tx - t0, 4);

        // R4 reset aborts reply and clears regs
        ready_mode = 0;
        send(8'h02);
        idle(2);
        check(tx_valid == 1'b1, "R4 reply pending before reset", tx_valid, 1);
        r0 = n_rst;
        send(8'h00);
        idle(2);
        check(n_rst == r0 + 1, "R4 soft_rst pulse", n_rst - r0, 1);
        check(!tx_valid, "R4 reply aborted", tx_valid, 0);
        check(divider == 0 && cap_len == 0 && post_len == 0 && flags == 0 && !armed,
              "R4 regs cleared", cap_len, 0);

        // R5 resync from mid-frame
        send(8'h01);
        send_long(8'h82, 32'h0000BEEF);
        idle(2);
        check(armed && flags == 16'hBEEF, "R5 setup", flags, 16'hBEEF);
        strobe_q.push_back({8'h81, 32'h00000011});
        send(8'h81); send(8'h11);
        r0 = n_rst;
        for (int i = 0; i < 5; i++) send(8'h00);
        idle(2);
        check(strobe_q.size() == 0, "R5 open frame completed with zeros", strobe_q.size(), 0);
        check(n_rst == r0 + 2, "R5 reset reached after resync", n_rst - r0, 2);
        check(!armed && flags == 0 && cap_len == 0, "R5 state cleared", flags, 0);
        t0 = n_run;
        send(8'h01);
        idle(1);
        check(n_run == t0 + 1 && armed, "R5 framing at opcode position", n_run - t0, 1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule